// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a counted run of items from a source address to a destination address for one peripheral. A 32-bit channel control word describes the whole transfer. Software loads that word together with the two start pointers while the channel is idle, then sets the enable. From then on the block serves the peripheral's requests. A burst request moves a power-of-two group of items. A single request moves one item.

Each item takes two bus cycles on a simple synchronous memory master. The first cycle reads from the source pointer, and the second cycle writes the returned data to the destination pointer. After every item the engine advances both pointers, lowers the remaining-count field and shows the updated values on its status outputs. When the final item is written, the engine sets its mode field to stopped, drops the enable and pulses completion.

Top module: `dma_xfer_engine`

## Requirements
- R1: Out of reset, enable_o, done_o and mem_req_o are 0, and all three status outputs read 0.
- R2: Control-word fields: mode [2:0] (1 = basic, 0 = stopped), transfer count [13:4], arbitration exponent [17:14], source size [25:24], source increment [27:26], destination size [29:28], destination increment [31:30]. Bits [23:3] other than those listed have no effect.
- R3: An increment code of 0, 1 or 2 advances its pointer by 1, 2 or 4 bytes after each item. Code 3 leaves the pointer unchanged. Source and destination follow their own codes.
- R4: The count field holds the number of items minus one. After each item that is not the last, the field on status_ctl_o drops by one. The transfer ends after exactly count+1 items.
- R5: A burst request moves 2^arb items back to back without returning to idle. If fewer items remain, it moves only those.
- R6: A single request moves exactly one item.
- R7: While use_burst_i is 1, single requests are ignored and start no bus activity.
- R8: Each item is one read cycle (mem_req_o=1, mem_we_o=0, address = source pointer), followed at once by one write cycle (mem_we_o=1, address = destination pointer). The write data is the read data returned in the write cycle, masked to the destination size: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits.
- R9: When the last item is written, the mode field becomes 0 and enable_o clears. done_o is high for exactly the following cycle.
- R10: Requests are ignored while enable_o is 0 or the mode field is not 1.
- R11: load_i is ignored while enable_o is 1, and the status outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load control word and pointers |
| ctl_word_i | input | 32 | Channel control word |
| src_ptr_i | input | 32 | Source start address |
| dst_ptr_i | input | 32 | Destination start address |
| enable_set_i | input | 1 | Set the channel enable |
| use_burst_i | input | 1 | Ignore single requests |
| single_req_i | input | 1 | Peripheral single request |
| burst_req_i | input | 1 | Peripheral burst request |
| enable_o | output | 1 | Channel enable state |
| done_o | output | 1 | Completion pulse |
| status_ctl_o | output | 32 | Live control word |
| status_src_o | output | 32 | Current source pointer |
| status_dst_o | output | 32 | Current destination pointer |
| mem_req_o | output | 1 | Bus cycle valid |
| mem_we_o | output | 1 | Bus write when 1, read when 0 |
| mem_addr_o | output | 32 | Bus address |
| mem_size_o | output | 2 | Item size code for the cycle |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read |

## Verification
The assertions assume that the memory returns read data in the cycle after the read, with no wait states. They also assume that the channel is never cleared except by its own completion. The bench's memory model answers every read on the following edge, and the bench never removes the enable from outside. The bench changes requests and use_burst_i only on falling edges. It does not load a control word while a transfer group is still running.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CTL_W = 32;
  localparam int CNT_W = 10;
  localparam logic [2:0] MODE_STOP  = 3'd0;
  localparam logic [2:0] MODE_BASIC = 3'd1;

  typedef struct packed {
    logic [1:0]       dst_inc;
    logic [1:0]       dst_size;
    logic [1:0]       src_inc;
    logic [1:0]       src_size;
    logic [5:0]       rsvd;
    logic [3:0]       arb;
    logic [CNT_W-1:0] count;
    logic             nxt_burst;
    logic [2:0]       mode;
  } ctl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} state_t;

  function automatic logic [2:0] inc_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] size);
    case (size)
      2'd0:    return 32'h0000_00ff;
      2'd1:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/dma_ptr_step.sv
module dma_ptr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [1:0]        inc_i,
  output logic [ADDR_W-1:0] nxt_o
);
  assign nxt_o = ptr_i + ADDR_W'(dma_pkg::inc_bytes(inc_i));
endmodule

// File: rtl/dma_grp_calc.sv
module dma_grp_calc #(
  parameter int CNT_W = 10
) (
  input  logic [3:0]       arb_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             burst_i,
  output logic [CNT_W:0]   len_o
);
  localparam int LEN_W = CNT_W + 1;
  logic [LEN_W-1:0] left, pow;

  always_comb begin
    left = {1'b0, count_i} + LEN_W'(1);
    pow  = LEN_W'(1) << arb_i;
    if (!burst_i)                        len_o = LEN_W'(1);
    else if (32'(arb_i) >= LEN_W)        len_o = left;
    else if (pow < left)                 len_o = pow;
    else                                 len_o = left;
  end
endmodule

// File: rtl/dma_beat_fsm.sv
module dma_beat_fsm #(
  parameter int CNT_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W:0]     len_i,
  input  logic               last_item_i,
  output dma_pkg::state_t    state_o
);
  import dma_pkg::*;
  state_t         state_q;
  logic [CNT_W:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RD;
          left_q  <= len_i;
        end
        ST_RD: state_q <= ST_WR;
        ST_WR: begin
          if (last_item_i || left_q == (CNT_W+1)'(1)) state_q <= ST_IDLE;
          else                                       state_q <= ST_RD;
          left_q <= left_q - (CNT_W+1)'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [31:0]       ctl_word_i,
  input  logic [ADDR_W-1:0] src_ptr_i,
  input  logic [ADDR_W-1:0] dst_ptr_i,
  input  logic              enable_set_i,
  input  logic              use_burst_i,
  input  logic              single_req_i,
  input  logic              burst_req_i,
  output logic              enable_o,
  output logic              done_o,
  output logic [31:0]       status_ctl_o,
  output logic [ADDR_W-1:0] status_src_o,
  output logic [ADDR_W-1:0] status_dst_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import dma_pkg::*;

  ctl_t              ctl_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic              en_q, done_q;
  state_t            state;
  logic              armed, start, last_item, beat;
  logic [CNT_W:0]    grp_len;

  assign armed     = en_q && (ctl_q.mode == MODE_BASIC);
  assign start     = armed && (burst_req_i || (single_req_i && !use_burst_i));
  assign last_item = (ctl_q.count == '0);
  assign beat      = (state == ST_WR);

  dma_grp_calc #(.CNT_W(CNT_W)) i_grp (
    .arb_i(ctl_q.arb), .count_i(ctl_q.count), .burst_i(burst_req_i), .len_o(grp_len)
  );

  dma_beat_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .len_i(grp_len),
    .last_item_i(last_item), .state_o(state)
  );

  dma_ptr_step #(.ADDR_W(ADDR_W)) i_src_step (.ptr_i(src_q), .inc_i(ctl_q.src_inc), .nxt_o(src_nxt));
  dma_ptr_step #(.ADDR_W(ADDR_W)) i_dst_step (.ptr_i(dst_q), .inc_i(ctl_q.dst_inc), .nxt_o(dst_nxt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !en_q) begin
        ctl_q <= ctl_t'(ctl_word_i);
        src_q <= src_ptr_i;
        dst_q <= dst_ptr_i;
      end
      if (enable_set_i) en_q <= 1'b1;
      if (beat) begin
        src_q <= src_nxt;
        dst_q <= dst_nxt;
        if (last_item) begin
          ctl_q.mode <= MODE_STOP;
          en_q       <= 1'b0;
          done_q     <= 1'b1;
        end else begin
          ctl_q.count <= ctl_q.count - CNT_W'(1);
        end
      end
    end
  end

  assign enable_o     = en_q;
  assign done_o       = done_q;
  assign status_ctl_o = ctl_q;
  assign status_src_o = src_q;
  assign status_dst_o = dst_q;
  assign mem_req_o    = (state != ST_IDLE);
  assign mem_we_o     = beat;
  assign mem_addr_o   = beat ? dst_q : src_q;
  assign mem_size_o   = beat ? ctl_q.dst_size : ctl_q.src_size;
  assign mem_wdata_o  = beat ? (mem_rdata_i & DATA_W'(size_mask(ctl_q.dst_size))) : '0;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        use_burst_i,
  input logic        burst_req_i,
  input logic        enable_o,
  input logic        done_o,
  input logic [31:0] status_ctl_o,
  input logic        mem_req_o,
  input logic        mem_we_o
);
  // R8
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (mem_req_o && mem_we_o));

  // R9
  done_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!enable_o && status_ctl_o[2:0] == 3'd0));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |-> !mem_req_o);

  // R10
  stopped_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && status_ctl_o[2:0] != 3'd1) |=> !mem_req_o);

  // R7
  single_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_req_o && use_burst_i && !burst_req_i) |=> !mem_req_o);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .use_burst_i(use_burst_i), .burst_req_i(burst_req_i),
  .enable_o(enable_o), .done_o(done_o), .status_ctl_o(status_ctl_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
);

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        load_i = 0, enable_set_i = 0, use_burst_i = 0, single_req_i = 0, burst_req_i = 0;
  logic [31:0] ctl_word_i = '0, src_ptr_i = '0, dst_ptr_i = '0;
  logic        enable_o, done_o, mem_req_o, mem_we_o;
  logic [31:0] status_ctl_o, status_src_o, status_dst_o, mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic [1:0]  mem_size_o;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dma_xfer_engine i_dma_xfer_engine (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .ctl_word_i(ctl_word_i),
    .src_ptr_i(src_ptr_i), .dst_ptr_i(dst_ptr_i), .enable_set_i(enable_set_i),
    .use_burst_i(use_burst_i), .single_req_i(single_req_i), .burst_req_i(burst_req_i),
    .enable_o(enable_o), .done_o(done_o), .status_ctl_o(status_ctl_o),
    .status_src_o(status_src_o), .status_dst_o(status_dst_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk_ctl(input int di, ds, si, ss, arb, cnt, mode);
    return {di[1:0], ds[1:0], si[1:0], ss[1:0], 6'd0, arb[3:0], cnt[9:0], 1'b0, mode[2:0]};
  endfunction

  function automatic logic [31:0] step(input int code);
    return (code == 0) ? 32'd1 : (code == 1) ? 32'd2 : (code == 2) ? 32'd4 : 32'd0;
  endfunction

  function automatic logic [31:0] msk(input int sz);
    return (sz == 0) ? 32'hff : (sz == 1) ? 32'hffff : 32'hffff_ffff;
  endfunction

  // synchronous memory model: data on the cycle after the read
  always_ff @(posedge clk)
    if (mem_req_o && !mem_we_o) mem_rdata_i <= pat(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] e_src, e_dst;
  int e_rem, e_si, e_di, e_ds, e_arb, e_mode;
  logic [31:0] e_ctl;

  task automatic load_cfg(input logic [31:0] ctl, input logic [31:0] s, input logic [31:0] d, input bit en);
    @(negedge clk);
    load_i = 1; ctl_word_i = ctl; src_ptr_i = s; dst_ptr_i = d;
    @(negedge clk);
    load_i = 0;
    e_ctl = ctl; e_src = s; e_dst = d; e_rem = int'(ctl[13:4]) + 1;
    e_si = int'(ctl[27:26]); e_di = int'(ctl[31:30]); e_ds = int'(ctl[29:28]);
    e_arb = int'(ctl[17:14]); e_mode = int'(ctl[2:0]);
    if (en) begin
      enable_set_i = 1;
      @(negedge clk);
      enable_set_i = 0;
    end
  endtask

  // pulse one request, follow the resulting group, check every bus cycle
  task automatic serve(input bit burst, input bit single);
    int n, exp_n, guard;
    logic [31:0] rd_addr;
    bit active;
    active = enable_o && (e_mode == 1) && e_rem > 0;
    if (!active) exp_n = 0;
    else if (burst) exp_n = ((1 << e_arb) < e_rem && e_arb < 11) ? (1 << e_arb) : e_rem;
    else if (single && !use_burst_i) exp_n = 1;
    else exp_n = 0;
    @(negedge clk);
    burst_req_i = burst; single_req_i = single;
    @(negedge clk);
    burst_req_i = 0; single_req_i = 0;
    n = 0; guard = 0; rd_addr = '0;
    while (mem_req_o && guard < 5000) begin
      if (!mem_we_o) begin
        chk(mem_addr_o == e_src, "R8 read addr", mem_addr_o, e_src);
        rd_addr = mem_addr_o;
      end else begin
        chk(mem_addr_o == e_dst, "R3 write addr", mem_addr_o, e_dst);
        chk(mem_wdata_o == (pat(rd_addr) & msk(e_ds)), "R8 wdata", mem_wdata_o, pat(rd_addr) & msk(e_ds));
        e_src += step(e_si); e_dst += step(e_di); e_rem--; n++;
      end
      guard++;
      @(negedge clk);
    end
    if (burst && exp_n > 0) chk(n == exp_n, "R5 burst group length", n, exp_n);
    else if (exp_n == 1)    chk(n == 1, "R6 single moves one", n, 1);
    else if (single && use_burst_i) chk(n == 0, "R7 single ignored", n, 0);
    else                    chk(n == 0, "R10 request ignored", n, 0);
    if (exp_n > 0) begin
      chk(status_src_o == e_src, "R3 src pointer", status_src_o, e_src);
      chk(status_dst_o == e_dst, "R3 dst pointer", status_dst_o, e_dst);
      if (e_rem == 0) begin
        chk(done_o == 1'b1, "R9 done pulse", done_o, 1);
        chk(enable_o == 1'b0, "R9 enable cleared", enable_o, 0);
        chk(status_ctl_o[2:0] == 3'd0, "R9 mode stopped", status_ctl_o[2:0], 0);
        e_mode = 0;
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
      end else begin
        chk(status_ctl_o[13:4] == 10'(e_rem - 1), "R4 count field", status_ctl_o[13:4], e_rem - 1);
        chk(done_o == 1'b0, "R9 no early done", done_o, 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    // R1
    chk(!enable_o && !done_o && !mem_req_o, "R1 reset outputs", {enable_o, done_o, mem_req_o}, 0);
    chk(status_ctl_o == 0 && status_src_o == 0 && status_dst_o == 0, "R1 reset status", status_ctl_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1;

    // R2 R3 R5: fixed dst, byte src, group of 4, 64 items
    load_cfg(mk_ctl(3, 0, 0, 0, 2, 63, 1), 32'h1000, 32'h4000_0000, 1);
    chk(enable_o == 1, "R2 enabled after set", enable_o, 1);
    for (int i = 0; i < 14; i++) serve(1, 0);
    serve(0, 1);
    serve(0, 1);
    while (e_rem > 0) serve(1, 0);
    chk(status_src_o == 32'h1040, "R4 64 items moved", status_src_o, 32'h1040);
    // R10: after completion requests are ignored
    serve(1, 0);

    // R5 truncation: 6 items, arb 2 -> 4 then 2
    load_cfg(mk_ctl(1, 1, 2, 2, 2, 5, 1), 32'h2000, 32'h3000, 1);
    serve(1, 0);
    serve(1, 0);

    // R7: use-burst ignores single
    load_cfg(mk_ctl(0, 0, 0, 0, 1, 3, 1), 32'h100, 32'h200, 1);
    use_burst_i = 1;
    serve(0, 1);
    chk(status_ctl_o[13:4] == 10'd3, "R7 count untouched", status_ctl_o[13:4], 3);
    serve(1, 0);
    // R11: load while enabled ignored
    @(negedge clk); load_i = 1; ctl_word_i = mk_ctl(2, 2, 2, 2, 0, 99, 1); src_ptr_i = 32'hdead;
    @(negedge clk); load_i = 0;
    chk(status_ctl_o == (e_ctl & ~32'h3ff0 | {18'd0, 10'(e_rem - 1), 4'd0}), "R11 ctl kept",
        status_ctl_o, e_ctl & ~32'h3ff0 | {18'd0, 10'(e_rem - 1), 4'd0});
    chk(status_src_o == e_src, "R11 src kept", status_src_o, e_src);
    serve(1, 0);
    use_burst_i = 0;

    // R10: loaded but not enabled; then mode 0 with enable
    load_cfg(mk_ctl(0, 0, 0, 0, 0, 2, 1), 32'h500, 32'h600, 0);
    serve(1, 0);
    serve(0, 1);
    load_cfg(mk_ctl(0, 0, 0, 0, 0, 2, 0), 32'h500, 32'h600, 1);
    serve(1, 0);
    chk(status_src_o == 32'h500, "R10 stopped mode no move", status_src_o, 32'h500);
    // clear leftover enable via a one-item transfer is impossible in mode 0; reset instead
    @(negedge clk); rst_ni = 0; @(negedge clk); rst_ni = 1;
    chk(enable_o == 0, "R1 reset clears enable", enable_o, 0);

    // random transfers, R2 R3 R4 R5 R6 R8
    for (int t = 0; t < 25; t++) begin
      int di, ds, si, ss, arb, cnt, g;
      di = $urandom_range(0, 3); ds = $urandom_range(0, 3);
      si = $urandom_range(0, 3); ss = $urandom_range(0, 3);
      arb = $urandom_range(0, 5); cnt = $urandom_range(0, 20);
      load_cfg(mk_ctl(di, ds, si, ss, arb, cnt, 1), $urandom, $urandom, 1);
      g = 0;
      while (e_rem > 0 && g < 200) begin
        if ($urandom_range(0, 2) == 0) serve(0, 1);
        else serve(1, 0);
        g++;
      end
      chk(enable_o == 0, "R4 transfer ends after count+1", enable_o, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule